// File: doc/BRIEF.md
# Single-Register MDIO Management Master

This block drives a clause-22 management bus (MDC clock, bidirectional MDIO data) on behalf of software that sees only one 32-bit command word. A single write to that word carries the PHY address, the register address, the direction, the write data and two start bits. When both start bits are set and the PHY address names one of the attached PHYs, the block sends one complete management frame. The busy bit then reads back as 1 until the frame ends. Software polls the busy bit. After a read, the captured PHY register value sits in the low half of the same word.

The MDC clock is the system clock divided by an even parameter. The data line changes only while MDC is low and is sampled as MDC rises. When the block is idle, or while a PHY answers a read, the master releases the data line. A PHY address outside the attached range is refused without touching the bus. A refused read returns all ones.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads 0, MDC is low and the data line is released (`mdio_oe` = 0).
- R2: A write while idle stores the written word. Busy (bit 31) becomes 1 only when bit 30 and bit 31 are both written as 1 and the PHY address is valid. In every other case busy reads 0 and no frame is sent.
- R3: While busy is 1, writes to the command word have no effect on the word or on the frame in progress.
- R4: The frame is sent as 32 ones, then start bits 0,1, then opcode 1,0 (read) or 0,1 (write), then PHY address bits [25:21] and register address bits [20:16], each MSB first. For a write it continues with turnaround 1,0 and data bits [15:0] MSB first. Bit 27 = 1 selects read.
- R5: Each frame bit lasts CLK_DIV clocks. MDC is low for the first CLK_DIV/2 clocks of a bit and high for the rest. MDIO and its enable change only in the clock where MDC falls or the frame starts, never while MDC is high.
- R6: For a read, the master releases MDIO for the two turnaround bits and the 16 data bits. It samples MDIO at each of the 16 data-bit rising edges of MDC, MSB first.
- R7: Busy clears exactly 64·CLK_DIV clocks after the accepting clock. For a read, bits [15:0] then hold the captured value. All other bits keep their written values.
- R8: A start with a PHY address of NUM_PHYS (default 5) or above sends no frame and leaves busy at 0. For a read it sets bits [15:0] to 16'hFFFF.
- R9: While busy is 0, MDC stays low and MDIO stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Current command word (busy, fields, read data) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data value driven by the master |
| mdio_oe | output | 1 | Master drives MDIO when 1 |
| mdio_i | input | 1 | Data value seen on the MDIO line |

## Verification
The command word changes in the clock after the write edge, so busy and the stored fields are due one edge after the strobe. Frame bit k starts k·CLK_DIV clocks after the accepting edge, MDC rises CLK_DIV/2 clocks into it, and busy with the read data lands exactly 64·CLK_DIV clocks after acceptance. The bench model counts elapsed clocks from the accepting edge and predicts MDC, the enable, the driven bit and the whole word for every cycle. Inputs change two time units after a rising edge, and the model compares at each falling edge, so each prediction is the state after the edge just passed.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    localparam int FRAME_BITS = 64;   // preamble + header + turnaround + data
    localparam int TA_FIRST   = 46;   // index of first turnaround bit in frame
    localparam int RD_FIRST   = 48;   // index of first data bit in frame
    localparam int F_PHY_LSB  = 21;
    localparam int F_REG_LSB  = 16;
    localparam int F_READ     = 27;
    localparam int F_ENABLE   = 30;
    localparam int F_BUSY     = 31;

    typedef logic [5:0] bit_idx_t;

    typedef struct packed {
        logic                  active;
        logic                  rd;
        logic                  mdc;
        logic                  oe;
        bit_idx_t              bidx;
        logic [FRAME_BITS-1:0] sh;
        logic [15:0]           cap;
    } eng_state_t;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic rise_o,
    output logic wrap_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = (cnt_q == CW'(CLK_DIV - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rise_o = run_i && (cnt_q == CW'(HALF - 1));
    assign wrap_o = run_i && (cnt_q == CW'(CLK_DIV - 1));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_cmd_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  is_read_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  mdio_i,
    output logic                  mdc_o,
    output logic                  mdio_o,
    output logic                  mdio_oe_o,
    output logic                  fin_o,
    output logic [15:0]           rdata_o
);
    eng_state_t s_d, s_q;
    logic       rise, wrap;
    bit_idx_t   nxt;

    mdio_mdc_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(start_i),
        .run_i    (s_q.active),
        .rise_o   (rise),
        .wrap_o   (wrap)
    );

    assign nxt = s_q.bidx + 6'd1;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.active = 1'b1;
            s_d.rd     = is_read_i;
            s_d.mdc    = 1'b0;
            s_d.oe     = 1'b1;           // first bit is preamble: driven
            s_d.bidx   = '0;
            s_d.sh     = frame_i;
        end else if (s_q.active) begin
            if (rise) begin
                s_d.mdc = 1'b1;
                if (s_q.rd && (s_q.bidx >= 6'(RD_FIRST)))
                    s_d.cap = {s_q.cap[14:0], mdio_i};
            end
            if (wrap) begin
                s_d.mdc = 1'b0;
                if (s_q.bidx == 6'(FRAME_BITS - 1)) begin
                    s_d.active = 1'b0;
                    s_d.oe     = 1'b0;
                end else begin
                    s_d.bidx = nxt;
                    s_d.sh   = {s_q.sh[FRAME_BITS-2:0], 1'b0};
                    s_d.oe   = !(s_q.rd && (nxt >= 6'(TA_FIRST)));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc_o     = s_q.mdc;
    assign mdio_o    = s_q.sh[FRAME_BITS-1];
    assign mdio_oe_o = s_q.oe;
    assign fin_o     = wrap && (s_q.bidx == 6'(FRAME_BITS - 1));
    assign rdata_o   = s_q.cap;
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int NUM_PHYS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr_en,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [31:0]           cmd_d, cmd_q;
    logic                  accept, go, phy_ok, start, fin, wr_read;
    logic [15:0]           cap;
    logic [FRAME_BITS-1:0] frame;

    assign accept  = cmd_wr_en && !cmd_q[F_BUSY];
    assign go      = cmd_wdata[F_ENABLE] && cmd_wdata[F_BUSY];
    assign phy_ok  = {1'b0, cmd_wdata[F_PHY_LSB +: 5]} < 6'(NUM_PHYS);
    assign start   = accept && go && phy_ok;
    assign wr_read = cmd_wdata[F_READ];

    assign frame = {32'hFFFF_FFFF, 2'b01,
                    wr_read ? 2'b10 : 2'b01,
                    cmd_wdata[F_PHY_LSB +: 5],
                    cmd_wdata[F_REG_LSB +: 5],
                    2'b10,
                    cmd_wdata[15:0]};

    always_comb begin
        cmd_d = cmd_q;
        if (accept) begin
            cmd_d         = cmd_wdata;
            cmd_d[F_BUSY] = go && phy_ok;
            if (go && !phy_ok && wr_read) cmd_d[15:0] = 16'hFFFF;
        end
        if (fin) begin
            cmd_d[F_BUSY] = 1'b0;
            if (cmd_q[F_READ]) cmd_d[15:0] = cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    mdio_frame_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .is_read_i(wr_read),
        .frame_i  (frame),
        .mdio_i   (mdio_i),
        .mdc_o    (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe_o(mdio_oe),
        .fin_o    (fin),
        .rdata_o  (cap)
    );

    assign cmd_rdata = cmd_q;
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk #(
    parameter int NUM_PHYS = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr_en,
    input logic [31:21] wr_hi,
    input logic [31:16] rd_hi,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic busy, start_req, bad_phy;
    assign busy      = rd_hi[31];
    assign start_req = wr_hi[31] && wr_hi[30];
    assign bad_phy   = {1'b0, wr_hi[25:21]} >= 6'(NUM_PHYS);

    assert_idle_mdc_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr_en) |=> (rd_hi[30:16] == $past(rd_hi[30:16])));

    assert_start_needs_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr_en && !start_req) |=> !busy);

    assert_bad_phy_no_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr_en && start_req && bad_phy) |=> (!busy && !mdc));

    assert_mdio_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_oe) && (!mdio_oe || $stable(mdio_o))));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk #(.NUM_PHYS(NUM_PHYS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr_en(cmd_wr_en),
    .wr_hi    (cmd_wdata[31:21]),
    .rd_hi    (cmd_rdata[31:16]),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
);

// File: tb/mdio_cmd_master_bench.sv
module mdio_cmd_master_bench;
    localparam int DIV  = 4;
    localparam int NPHY = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_drv = 1'b1;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string tag = "R1";

    // reference model state (state after the most recent rising edge)
    logic [31:0] m_reg = '0;
    logic        m_busy = 1'b0;
    logic        m_rd = 1'b0;
    int          m_e = 0;
    logic [63:0] m_frame = '0;
    logic [15:0] phy_val = '0;
    int          phy_bit = 0;

    always #5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    mdio_cmd_master #(.CLK_DIV(DIV), .NUM_PHYS(NPHY)) u_mdio_cmd_master (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // behavioural PHY: answers reads, drives data after each MDC fall
    always @(posedge mdc) phy_bit = phy_bit + 1;
    always @(negedge mdc) begin
        if (phy_bit >= 48 && phy_bit < 64) phy_drv = phy_val[15 - (phy_bit - 48)];
        else if (phy_bit == 47)            phy_drv = 1'b0;
        else                               phy_drv = 1'b1;
    end

    function automatic logic [31:0] mk(input logic rd, input int phy, input int rg,
                                       input logic [15:0] dat, input logic en,
                                       input logic bsy);
        logic [31:0] w;
        w        = '0;
        w[31]    = bsy;
        w[30]    = en;
        w[27]    = rd;
        w[25:21] = 5'(phy);
        w[20:16] = 5'(rg);
        w[15:0]  = dat;
        return w;
    endfunction

    always @(negedge clk) begin
        int  k;
        logic e_mdc, e_oe;
        cycles++;
        if (rst_n) begin
            k     = m_e / DIV;
            e_mdc = m_busy && ((m_e % DIV) >= DIV / 2);
            e_oe  = m_busy && !(m_rd && k >= 46);
            vectors++;
            if (mdc !== e_mdc) begin
                miscompares++;
                $display("FAIL R5 mdc got %b expected %b (cycle %0d)", mdc, e_mdc, m_e);
            end
            if (mdio_oe !== e_oe) begin
                miscompares++;
                $display("FAIL %s mdio_oe got %b expected %b", m_busy ? "R6" : "R9",
                         mdio_oe, e_oe);
            end
            if (e_oe && mdio_o !== m_frame[63 - k]) begin
                miscompares++;
                $display("FAIL R4 mdio_o bit %0d got %b expected %b", k, mdio_o,
                         m_frame[63 - k]);
            end
            if (cmd_rdata !== m_reg) begin
                miscompares++;
                $display("FAIL %s cmd_rdata got %h expected %h", tag, cmd_rdata, m_reg);
            end
        end
        // advance model to the state after the next rising edge
        if (!rst_n) begin
            m_reg = '0; m_busy = 1'b0; m_e = 0;
        end else if (m_busy) begin
            m_e++;
            if (m_e == 64 * DIV) begin
                m_busy    = 1'b0;
                m_reg[31] = 1'b0;
                if (m_rd) m_reg[15:0] = phy_val;
            end
        end else if (cmd_wr_en) begin
            m_reg = cmd_wdata;
            if (cmd_wdata[31] && cmd_wdata[30]) begin
                if (int'(cmd_wdata[25:21]) < NPHY) begin
                    m_busy  = 1'b1;
                    m_e     = 0;
                    m_rd    = cmd_wdata[27];
                    m_frame = {32'hFFFF_FFFF, 2'b01, cmd_wdata[27] ? 2'b10 : 2'b01,
                               cmd_wdata[25:16], 2'b10, cmd_wdata[15:0]};
                end else begin
                    m_reg[31] = 1'b0;
                    if (cmd_wdata[27]) m_reg[15:0] = 16'hFFFF;
                end
            end else begin
                m_reg[31] = 1'b0;
            end
        end
    end

    task automatic issue(input logic [31:0] w);
        @(posedge clk); #2;
        if (!m_busy) phy_bit = 0;
        cmd_wr_en = 1'b1;
        cmd_wdata = w;
        @(posedge clk); #2;
        cmd_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_done;
        while (m_busy) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        tag = "R1";                               // reset state
        idle(3); rst_n = 1'b1; idle(4);

        tag = "R4";                               // write frame
        issue(mk(1'b0, 2, 5, 16'hA5C3, 1'b1, 1'b1)); wait_done; idle(3);

        tag = "R6";                               // read frame, turnaround release
        phy_val = 16'h1234;
        issue(mk(1'b1, 4, 31, 16'h0000, 1'b1, 1'b1)); wait_done; idle(3);

        tag = "R3";                               // writes during busy ignored
        phy_val = 16'hBEEF;
        issue(mk(1'b1, 1, 3, 16'h0000, 1'b1, 1'b1));
        idle(40);
        issue(mk(1'b0, 3, 7, 16'h5555, 1'b1, 1'b1));
        idle(100);
        issue(mk(1'b1, 0, 0, 16'h0000, 1'b1, 1'b1));
        wait_done; idle(3);

        tag = "R2";                               // start needs both bits
        issue(mk(1'b0, 1, 2, 16'h1111, 1'b1, 1'b0)); idle(6);
        issue(mk(1'b0, 1, 2, 16'h2222, 1'b0, 1'b1)); idle(6);
        issue(mk(1'b1, 3, 9, 16'h3333, 1'b0, 1'b0)); idle(6);

        tag = "R8";                               // out-of-range PHY refused
        issue(mk(1'b1, 5, 1, 16'h0000, 1'b1, 1'b1)); idle(10);
        issue(mk(1'b1, 31, 1, 16'h0042, 1'b1, 1'b1)); idle(10);
        issue(mk(1'b0, 7, 2, 16'h7777, 1'b1, 1'b1)); idle(10);

        tag = "R7";                               // end timing, back to back
        phy_val = 16'h8001;
        issue(mk(1'b1, 0, 0, 16'h0000, 1'b1, 1'b1)); wait_done;
        issue(mk(1'b0, 3, 31, 16'h0001, 1'b1, 1'b1)); wait_done;
        phy_val = 16'h0000;
        issue(mk(1'b1, 2, 16, 16'hFFFF, 1'b1, 1'b1)); wait_done; idle(5);

        finish_run();
    end
endmodule